// File: doc/BRIEF.md
# Monitor Alarm and Warning Flag Engine

This block turns the stream of conversion results from a round-robin monitor into status flags. The monitor produces one result at a time for temperature, supply voltage and three analog inputs (bias, transmit power and received power). Each result arrives as a one-cycle valid strobe with a channel index and a 16-bit value. The engine compares the result against that channel's high and low alarm limits and its high and low warning limits. It records that the channel has a fresh reading and keeps the latest temperature class.

Three fast-trip flags (bias, transmit power, received power) compare the top byte of each channel's latest reading with a threshold. The threshold comes from a small bank picked by the current temperature bin. A host can force any flag to a value it has written, through a per-flag override enable, and it can rearm the per-channel "updated" bits through a small register write port.

Top module: `mon_flag_engine`

## Requirements
- R1: A high flag (alarm or warning) for a channel becomes 1 when that channel's converted value is strictly greater than its high limit, and 0 otherwise. Layout: `alm_o`/`wrn_o` bits [4:0] are the high flags and bits [9:5] are the low flags. Bit i within each half belongs to channel index i: 0 temperature, 1 supply, 2 bias, 3 transmit power, 4 received power.
- R2: A low flag becomes 1 when the converted value is strictly less than its low limit, and 0 otherwise. A value equal to the limit sets neither flag.
- R3: Only bits [15:4] of a conversion and of a limit take part in a comparison; bits [3:0] are ignored.
- R4: Channel 0 (temperature) is compared as two's-complement signed. Channels 1 to 4 are compared as unsigned.
- R5: The alarm and warning flags of a channel change only in the cycle after a conversion for that channel. A change of limits alone leaves the flags unchanged.
- R6: A write to register address 0 loads `upd_o` from `wr_data_i[4:0]`. A valid conversion sets bit `conv_ch_i` of `upd_o` one cycle later, and this takes precedence over a write in the same cycle.
- R7: Each flag has an override enable. While it is 1, the flag output shows the host value instead of the comparator result. Host values are written at address 1 (alarm, same layout as `alm_o`), address 2 (warning) and address 3 (fast-trip, same layout as `fast_o`). Writing a host value has no visible effect while the override is 0.
- R8: The temperature bin comes from bits [15:8] of the latest temperature conversion, read as signed degrees. Bin 0 is below -8. Bins 1 to 6 cover [-8,8), [8,24), [24,40), [40,56), [56,72) and [72,88). Bin 7 is 88 and above.
- R9: The bias fast trip uses threshold entry `bin` of its eight 8-bit entries, entry k at bits [8k+7:8k]. The transmit-power and received-power fast trips use entry `bin/2` of their four entries.
- R10: A fast-trip flag is 1 when bits [15:8] of that channel's latest conversion are strictly greater than the selected threshold. `fast_o` bit 0 is bias, bit 1 is transmit power and bit 2 is received power. A threshold change is reflected without waiting for a conversion.
- R11: A strobe with a channel index of 5 or more changes no flag, no updated bit and no stored reading.
- R12: Synchronous reset clears all flags, updated bits, host values, stored readings and the temperature bin to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| conv_vld_i | input | 1 | Conversion result valid strobe |
| conv_ch_i | input | 3 | Channel index of the result |
| conv_val_i | input | 16 | Conversion result |
| lim_hi_alm_i | input | 80 | High alarm limits, 16 bits per channel, channel i at [16i+15:16i] |
| lim_lo_alm_i | input | 80 | Low alarm limits |
| lim_hi_wrn_i | input | 80 | High warning limits |
| lim_lo_wrn_i | input | 80 | Low warning limits |
| trip_bias_i | input | 64 | Bias fast-trip thresholds, eight 8-bit entries |
| trip_pow_i | input | 32 | Transmit-power fast-trip thresholds, four entries |
| trip_rx_i | input | 32 | Received-power fast-trip thresholds, four entries |
| ovr_alm_i | input | 10 | Alarm flag override enables |
| ovr_wrn_i | input | 10 | Warning flag override enables |
| ovr_fast_i | input | 3 | Fast-trip flag override enables |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 updated, 1 alarm host, 2 warning host, 3 fast host |
| wr_data_i | input | 16 | Register write data |
| alm_o | output | 10 | Alarm flags |
| wrn_o | output | 10 | Warning flags |
| fast_o | output | 3 | Fast-trip flags |
| upd_o | output | 5 | Per-channel conversion-updated bits |

## Verification
A wrong comparator or signedness choice shows on `alm_o`/`wrn_o` in the cycle right after the offending conversion. The temperature range flips between the high and low flag for negative readings. A flag that is refreshed by the wrong event shows up as a flag changing while only the limits moved. A stale or misplaced temperature bin is not visible directly. It appears on `fast_o` as soon as a reading whose top byte lies between two neighbouring thresholds meets the wrong entry. The bench therefore sweeps the temperature across every bin edge with such a reading held.

// File: rtl/mon_flag_pkg.sv
package mon_flag_pkg;

    // Channel indices as delivered with each conversion result
    typedef enum logic [2:0] {
        CH_TEMP   = 3'd0,
        CH_SUPPLY = 3'd1,
        CH_BIAS   = 3'd2,
        CH_POW    = 3'd3,
        CH_RX     = 3'd4
    } mon_ch_e;

    // Host-writable registers
    typedef enum logic [1:0] {
        REG_UPD      = 2'd0,
        REG_ALM_HOST = 2'd1,
        REG_WRN_HOST = 2'd2,
        REG_FST_HOST = 2'd3
    } mon_reg_e;

endpackage

// File: rtl/mon_lim_cmp.sv
module mon_lim_cmp #(
    parameter int VW        = 16,
    parameter int SIGW      = 12,
    parameter bit IS_SIGNED = 1'b0
) (
    input  logic [VW-1:0] val_i,
    input  logic [VW-1:0] hi_i,
    input  logic [VW-1:0] lo_i,
    output logic          above_o,
    output logic          below_o
);
    logic [SIGW-1:0] v_s, h_s, l_s;

    assign v_s = val_i[VW-1 -: SIGW];
    assign h_s = hi_i[VW-1 -: SIGW];
    assign l_s = lo_i[VW-1 -: SIGW];

    generate
        if (IS_SIGNED) begin : g_signed
            assign above_o = $signed(v_s) > $signed(h_s);
            assign below_o = $signed(v_s) < $signed(l_s);
        end else begin : g_unsigned
            assign above_o = v_s > h_s;
            assign below_o = v_s < l_s;
        end
    endgenerate
endmodule

// File: rtl/mon_temp_bin.sv
module mon_temp_bin #(
    parameter int VW       = 16,
    parameter int DEGW     = 8,
    parameter int NBIN     = 8,
    parameter int LOW_EDGE = -8,
    parameter int STEP_LG  = 4,
    localparam int BW      = $clog2(NBIN)
) (
    input  logic [VW-1:0] temp_i,
    output logic [BW-1:0] bin_o
);
    localparam int XW = DEGW + 2;
    localparam logic signed [XW-1:0] EDGE_X = XW'(LOW_EDGE);
    localparam logic [XW-1:0] TOP_STEP = XW'(NBIN - 2);

    logic [DEGW-1:0]        deg;
    logic signed [XW-1:0]   deg_x;
    logic signed [XW-1:0]   rel;
    logic [XW-1:0]          step;

    assign deg   = temp_i[VW-1 -: DEGW];
    assign deg_x = {{2{deg[DEGW-1]}}, deg};
    assign rel   = deg_x - EDGE_X;
    assign step  = XW'(rel) >> STEP_LG;

    always_comb begin
        if (rel[XW-1]) begin
            bin_o = '0;
        end else if (step > TOP_STEP) begin
            bin_o = BW'(NBIN - 1);
        end else begin
            bin_o = BW'(step) + BW'(1);
        end
    end
endmodule

// File: rtl/mon_fast_sel.sv
module mon_fast_sel #(
    parameter int TW   = 8,
    parameter int NTHR = 4,
    parameter int NBIN = 8,
    localparam int BW  = $clog2(NBIN),
    localparam int SW  = (NTHR > 1) ? $clog2(NTHR) : 1,
    localparam int SH  = BW - $clog2(NTHR)
) (
    input  logic [NTHR*TW-1:0] thr_i,
    input  logic [BW-1:0]      bin_i,
    input  logic [TW-1:0]      lvl_i,
    output logic               trip_o
);
    logic [SW-1:0] sel;
    logic [TW-1:0] thr;

    assign sel    = SW'(bin_i >> SH);
    assign thr    = thr_i[sel*TW +: TW];
    assign trip_o = lvl_i > thr;
endmodule

// File: rtl/mon_flag_engine.sv
module mon_flag_engine
    import mon_flag_pkg::*;
#(
    parameter int NCH   = 5,
    parameter int VW    = 16,
    parameter int SIGW  = 12,
    parameter int TW    = 8,
    parameter int NBIN  = 8,
    parameter int NSHRT = 4,
    parameter int DW    = 16,
    localparam int NFST = 3,
    localparam int CHW  = 3,
    localparam int BW   = $clog2(NBIN),
    localparam int FW   = 2 * NCH
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               conv_vld_i,
    input  logic [CHW-1:0]     conv_ch_i,
    input  logic [VW-1:0]      conv_val_i,
    input  logic [NCH*VW-1:0]  lim_hi_alm_i,
    input  logic [NCH*VW-1:0]  lim_lo_alm_i,
    input  logic [NCH*VW-1:0]  lim_hi_wrn_i,
    input  logic [NCH*VW-1:0]  lim_lo_wrn_i,
    input  logic [NBIN*TW-1:0] trip_bias_i,
    input  logic [NSHRT*TW-1:0] trip_pow_i,
    input  logic [NSHRT*TW-1:0] trip_rx_i,
    input  logic [FW-1:0]      ovr_alm_i,
    input  logic [FW-1:0]      ovr_wrn_i,
    input  logic [NFST-1:0]    ovr_fast_i,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_addr_i,
    input  logic [DW-1:0]      wr_data_i,
    output logic [FW-1:0]      alm_o,
    output logic [FW-1:0]      wrn_o,
    output logic [NFST-1:0]    fast_o,
    output logic [NCH-1:0]     upd_o
);
    localparam int FST_BASE = int'(CH_BIAS);

    typedef struct packed {
        logic [NCH-1:0]     alm_hi;
        logic [NCH-1:0]     alm_lo;
        logic [NCH-1:0]     wrn_hi;
        logic [NCH-1:0]     wrn_lo;
        logic [NCH-1:0]     upd;
        logic [FW-1:0]      alm_host;
        logic [FW-1:0]      wrn_host;
        logic [NFST-1:0]    fst_host;
        logic [BW-1:0]      bin;
        logic [NFST*TW-1:0] lvl;
    } eng_state_t;

    eng_state_t st_d, st_q;

    logic [NCH-1:0]  cmp_alm_hi, cmp_alm_lo, cmp_wrn_hi, cmp_wrn_lo;
    logic [BW-1:0]   bin_new;
    logic [NFST-1:0] fst_raw;
    logic            conv_ok;

    // Per-channel limit comparators; channel 0 is signed temperature
    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            mon_lim_cmp #(
                .VW(VW), .SIGW(SIGW), .IS_SIGNED(c == int'(CH_TEMP))
            ) alm_cmp_i (
                .val_i(conv_val_i),
                .hi_i(lim_hi_alm_i[c*VW +: VW]),
                .lo_i(lim_lo_alm_i[c*VW +: VW]),
                .above_o(cmp_alm_hi[c]),
                .below_o(cmp_alm_lo[c])
            );
            mon_lim_cmp #(
                .VW(VW), .SIGW(SIGW), .IS_SIGNED(c == int'(CH_TEMP))
            ) wrn_cmp_i (
                .val_i(conv_val_i),
                .hi_i(lim_hi_wrn_i[c*VW +: VW]),
                .lo_i(lim_lo_wrn_i[c*VW +: VW]),
                .above_o(cmp_wrn_hi[c]),
                .below_o(cmp_wrn_lo[c])
            );
        end
    endgenerate

    mon_temp_bin #(
        .VW(VW), .DEGW(TW), .NBIN(NBIN), .LOW_EDGE(-8), .STEP_LG(4)
    ) bin_i (
        .temp_i(conv_val_i),
        .bin_o(bin_new)
    );

    // Fast trips: bias has a full bank, the other two a short bank
    generate
        for (genvar f = 0; f < NFST; f++) begin : g_fst
            if (f == 0) begin : g_full
                mon_fast_sel #(.TW(TW), .NTHR(NBIN), .NBIN(NBIN)) sel_i (
                    .thr_i(trip_bias_i), .bin_i(st_q.bin),
                    .lvl_i(st_q.lvl[f*TW +: TW]), .trip_o(fst_raw[f])
                );
            end else if (f == 1) begin : g_pow
                mon_fast_sel #(.TW(TW), .NTHR(NSHRT), .NBIN(NBIN)) sel_i (
                    .thr_i(trip_pow_i), .bin_i(st_q.bin),
                    .lvl_i(st_q.lvl[f*TW +: TW]), .trip_o(fst_raw[f])
                );
            end else begin : g_rx
                mon_fast_sel #(.TW(TW), .NTHR(NSHRT), .NBIN(NBIN)) sel_i (
                    .thr_i(trip_rx_i), .bin_i(st_q.bin),
                    .lvl_i(st_q.lvl[f*TW +: TW]), .trip_o(fst_raw[f])
                );
            end
        end
    endgenerate

    assign conv_ok = conv_vld_i && (conv_ch_i < CHW'(NCH));

    always_comb begin
        st_d = st_q;

        if (wr_en_i) begin
            case (mon_reg_e'(wr_addr_i))
                REG_UPD:      st_d.upd      = wr_data_i[NCH-1:0];
                REG_ALM_HOST: st_d.alm_host = wr_data_i[FW-1:0];
                REG_WRN_HOST: st_d.wrn_host = wr_data_i[FW-1:0];
                default:      st_d.fst_host = wr_data_i[NFST-1:0];
            endcase
        end

        if (conv_ok) begin
            st_d.alm_hi[conv_ch_i] = cmp_alm_hi[conv_ch_i];
            st_d.alm_lo[conv_ch_i] = cmp_alm_lo[conv_ch_i];
            st_d.wrn_hi[conv_ch_i] = cmp_wrn_hi[conv_ch_i];
            st_d.wrn_lo[conv_ch_i] = cmp_wrn_lo[conv_ch_i];
            st_d.upd[conv_ch_i]    = 1'b1;
            if (conv_ch_i == CH_TEMP) begin
                st_d.bin = bin_new;
            end
            for (int f = 0; f < NFST; f++) begin
                if (conv_ch_i == CHW'(FST_BASE + f)) begin
                    st_d.lvl[f*TW +: TW] = conv_val_i[VW-1 -: TW];
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alm_o  = (ovr_alm_i & st_q.alm_host)
                  | (~ovr_alm_i & {st_q.alm_lo, st_q.alm_hi});
    assign wrn_o  = (ovr_wrn_i & st_q.wrn_host)
                  | (~ovr_wrn_i & {st_q.wrn_lo, st_q.wrn_hi});
    assign fast_o = (ovr_fast_i & st_q.fst_host) | (~ovr_fast_i & fst_raw);
    assign upd_o  = st_q.upd;
endmodule

// File: rtl/mon_flag_engine_chk.sv
module mon_flag_engine_chk #(
    parameter int NCH = 5,
    parameter int CHW = 3,
    parameter int FW  = 10
) (
    input logic           clk_i,
    input logic           rst_i,
    input logic           conv_vld_i,
    input logic [CHW-1:0] conv_ch_i,
    input logic           wr_en_i,
    input logic [FW-1:0]  ovr_alm_i,
    input logic [FW-1:0]  ovr_wrn_i,
    input logic [FW-1:0]  alm_o,
    input logic [FW-1:0]  wrn_o,
    input logic [NCH-1:0] upd_o
);
    // R12
    reset_clear_chk: assert property (@(posedge clk_i)
        rst_i |=> (upd_o == '0));

    // R6
    upd_set_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (conv_vld_i && conv_ch_i < CHW'(NCH)) |=> upd_o[$past(conv_ch_i)]);

    // R6
    upd_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!conv_vld_i && !wr_en_i) |=> $stable(upd_o));

    // R5
    alm_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!conv_vld_i && !wr_en_i) |=> ($stable(ovr_alm_i) -> $stable(alm_o)));

    // R5
    wrn_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!conv_vld_i && !wr_en_i) |=> ($stable(ovr_wrn_i) -> $stable(wrn_o)));

    // R11
    bad_ch_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (conv_vld_i && conv_ch_i >= CHW'(NCH) && !wr_en_i) |=>
            ($stable(upd_o) && ($stable(ovr_alm_i) -> $stable(alm_o))));
endmodule

bind mon_flag_engine mon_flag_engine_chk #(
    .NCH(NCH), .CHW(CHW), .FW(FW)
) chk_i (
    .clk_i(clk_i),
    .rst_i(rst_i),
    .conv_vld_i(conv_vld_i),
    .conv_ch_i(conv_ch_i),
    .wr_en_i(wr_en_i),
    .ovr_alm_i(ovr_alm_i),
    .ovr_wrn_i(ovr_wrn_i),
    .alm_o(alm_o),
    .wrn_o(wrn_o),
    .upd_o(upd_o)
);

// File: tb/mon_flag_engine_tb_top.sv
module mon_flag_engine_tb_top;
    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic        conv_vld_i = 1'b0;
    logic [2:0]  conv_ch_i = '0;
    logic [15:0] conv_val_i = '0;
    logic [79:0] lim_hi_alm_i, lim_lo_alm_i, lim_hi_wrn_i, lim_lo_wrn_i;
    logic [63:0] trip_bias_i;
    logic [31:0] trip_pow_i, trip_rx_i;
    logic [9:0]  ovr_alm_i = '0;
    logic [9:0]  ovr_wrn_i = '0;
    logic [2:0]  ovr_fast_i = '0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_addr_i = '0;
    logic [15:0] wr_data_i = '0;
    logic [9:0]  alm_o, wrn_o;
    logic [2:0]  fast_o;
    logic [4:0]  upd_o;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk_i = ~clk_i;

    mon_flag_engine dut_i (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic conv(input logic [2:0] ch, input logic [15:0] v);
        @(negedge clk_i);
        conv_vld_i = 1'b1; conv_ch_i = ch; conv_val_i = v;
        @(negedge clk_i);
        conv_vld_i = 1'b0;
    endtask

    task automatic wreg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk_i);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk_i);
        wr_en_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12 alm", 32'(alm_o), 0);
        chk("R12 wrn", 32'(wrn_o), 0);
        chk("R12 upd", 32'(upd_o), 0);
        chk("R12 fast", 32'(fast_o), 0);
    endtask

    task automatic t_temp_signed();
        conv(3'd0, 16'h5000);
        chk("R1 R4 temp hi alm", 32'(alm_o), 32'h001);
        chk("R1 temp hi wrn", 32'(wrn_o), 32'h001);
        conv(3'd0, 16'hEC00);
        chk("R2 R4 temp lo alm", 32'(alm_o), 32'h020);
        chk("R2 R4 temp lo wrn", 32'(wrn_o), 32'h020);
        conv(3'd0, 16'h1900);
        chk("R4 temp in range", 32'(alm_o), 0);
    endtask

    task automatic t_supply_edges();
        conv(3'd1, 16'h8000);
        chk("R1 equal not high", 32'(alm_o), 0);
        conv(3'd1, 16'h800F);
        chk("R3 low bits ignored", 32'(alm_o), 0);
        conv(3'd1, 16'h8010);
        chk("R1 supply high", 32'(alm_o), 32'h002);
        chk("R1 supply warn high", 32'(wrn_o), 32'h002);
        conv(3'd1, 16'h3FF0);
        chk("R2 supply low", 32'(alm_o), 32'h040);
        conv(3'd1, 16'h4000);
        chk("R2 equal not low", 32'(alm_o), 0);
        chk("R2 supply warn low", 32'(wrn_o), 32'h040);
    endtask

    task automatic t_limit_hold();
        lim_lo_alm_i[16 +: 16] = 16'h5000;
        repeat (3) @(negedge clk_i);
        chk("R5 limit change alone", 32'(alm_o), 0);
        conv(3'd1, 16'h4000);
        chk("R5 refreshed on conversion", 32'(alm_o), 32'h040);
        lim_lo_alm_i[16 +: 16] = 16'h4000;
        conv(3'd1, 16'h6000);
        chk("R5 supply cleared", 32'(alm_o), 0);
        chk("R5 supply warn cleared", 32'(wrn_o), 0);
    endtask

    task automatic t_updated();
        chk("R6 bits set", 32'(upd_o), 32'h03);
        wreg(2'd0, 16'h0000);
        chk("R6 host clear", 32'(upd_o), 0);
        conv(3'd3, 16'h3800);
        chk("R6 power set", 32'(upd_o), 32'h08);
        @(negedge clk_i);
        wr_en_i = 1'b1; wr_addr_i = 2'd0; wr_data_i = '0;
        conv_vld_i = 1'b1; conv_ch_i = 3'd4; conv_val_i = 16'h3800;
        @(negedge clk_i);
        wr_en_i = 1'b0; conv_vld_i = 1'b0;
        chk("R6 conversion beats write", 32'(upd_o), 32'h10);
    endtask

    task automatic t_override();
        wreg(2'd1, 16'h0001);
        chk("R7 host value hidden", 32'(alm_o), 0);
        ovr_alm_i = 10'h001;
        @(negedge clk_i);
        chk("R7 override shows host", 32'(alm_o), 32'h001);
        conv(3'd0, 16'h5000);
        wreg(2'd1, 16'h0000);
        chk("R7 override masks compare", 32'(alm_o), 0);
        ovr_alm_i = '0;
        @(negedge clk_i);
        chk("R7 release shows compare", 32'(alm_o), 32'h001);
        wreg(2'd2, 16'h0200);
        ovr_wrn_i = 10'h200;
        @(negedge clk_i);
        chk("R7 warn override", 32'(wrn_o), 32'h201);
        ovr_wrn_i = '0;
        conv(3'd0, 16'h1900);
    endtask

    task automatic t_fast();
        for (int k = 0; k < 8; k++) trip_bias_i[k*8 +: 8] = 8'(8'h20 + k * 8);
        trip_pow_i = {8'h20, 8'h30, 8'h40, 8'h50};
        trip_rx_i  = 32'hFFFF_FFFF;
        conv(3'd2, 16'h3500);
        conv(3'd0, 16'hF700);
        chk("R8 R9 bin0 below -8", 32'(fast_o), 32'h1);
        conv(3'd0, 16'hF800);
        chk("R8 R9 bin1 at -8", 32'(fast_o), 32'h1);
        conv(3'd0, 16'h0800);
        chk("R8 R9 bin2 at 8", 32'(fast_o), 32'h1);
        conv(3'd0, 16'h1800);
        chk("R8 R10 bin3 at 24", 32'(fast_o), 32'h0);
        conv(3'd0, 16'h2700);
        chk("R8 R9 bin3 at 39", 32'(fast_o), 32'h0);
        conv(3'd0, 16'h2800);
        chk("R8 R9 bin4 pow short bank", 32'(fast_o), 32'h2);
        conv(3'd0, 16'h5700);
        chk("R8 R9 bin6 at 87", 32'(fast_o), 32'h2);
        conv(3'd0, 16'h5800);
        chk("R8 R9 bin7 at 88", 32'(fast_o), 32'h2);
        trip_bias_i[56 +: 8] = 8'h10;
        @(negedge clk_i);
        chk("R10 threshold change live", 32'(fast_o), 32'h3);
        wreg(2'd3, 16'h0004);
        ovr_fast_i = 3'b111;
        @(negedge clk_i);
        chk("R7 fast override", 32'(fast_o), 32'h4);
        ovr_fast_i = '0;
    endtask

    task automatic t_bad_channel();
        logic [9:0] a0, w0;
        logic [2:0] f0;
        wreg(2'd0, 16'h0000);
        a0 = alm_o; w0 = wrn_o; f0 = fast_o;
        conv(3'd5, 16'hFFFF);
        conv(3'd7, 16'h0000);
        chk("R11 upd untouched", 32'(upd_o), 0);
        chk("R11 alm untouched", 32'(alm_o), 32'(a0));
        chk("R11 wrn untouched", 32'(wrn_o), 32'(w0));
        chk("R11 fast untouched", 32'(fast_o), 32'(f0));
    endtask

    initial begin
        lim_hi_alm_i = {16'hC000, 16'hC000, 16'hC000, 16'h8000, 16'h4600};
        lim_lo_alm_i = {16'h1000, 16'h1000, 16'h1000, 16'h4000, 16'hF600};
        lim_hi_wrn_i = {16'hB000, 16'hB000, 16'hB000, 16'h7000, 16'h4000};
        lim_lo_wrn_i = {16'h2000, 16'h2000, 16'h2000, 16'h5000, 16'hFB00};
        trip_bias_i = '0;
        trip_pow_i = '0;
        trip_rx_i = '0;
        repeat (3) @(negedge clk_i);
        rst_i = 1'b0;
        @(negedge clk_i);
        t_reset();
        t_temp_signed();
        t_supply_edges();
        t_limit_hold();
        t_updated();
        t_override();
        t_fast();
        t_bad_channel();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule